// File: doc/BRIEF.md
# Indexed Interrupt Register Port

This block is the host-facing register window of a network controller. The host reaches it through two byte-wide ports. A write to the address port selects a register index. Later accesses to the data port read or write the register at that index. Reads are combinational from the held index, so the read data is valid as soon as the index settles.

Two registers are implemented. The first is an interrupt status register. Its low four bits are set by single-cycle event pulses from the receive and transmit logic, and the host clears a bit by writing 1 to it. The second is an interrupt mask register. Its low four bits enable the matching status bits, and its top bit enables automatic pointer wrap in the packet memory. A single registered interrupt line is raised whenever an enabled status bit is set. The upper two status bits are read-only and show the host bus width taken from a strap input.

Top module: `nic_regport`

## Requirements
- R1: A data-port access targets the index most recently written to the address port. After reset the index is 0x00.
- R2: Reset clears the status bits, the mask bits and the interrupt output.
- R3: An event pulse sets its status bit at the next clock edge. The bit positions are: bit 0 receive done, bit 1 transmit done, bit 2 receive overflow, bit 3 overflow-counter overflow. The status register is read at index 0xFE.
- R4: A data write at index 0xFE clears every status bit written as 1 and leaves every bit written as 0 unchanged.
- R5: If an event arrives in the same cycle as a write-1 clear of its own bit, the bit stays set.
- R6: Status bits 7:6 read the bus-mode strap: 00 means 16-bit, 01 means 32-bit, 10 means 8-bit. Writes do not change these bits, and status bits 5:4 read 0.
- R7: The mask is read and written at index 0xFF. Bits 3:0 and bit 7 are writable, and bits 6:4 read 0. Output `ptr_wrap` follows mask bit 7.
- R8: `irq` is 1 exactly when (status[3:0] & mask[3:0]) was nonzero in the previous cycle. It therefore follows a status or mask change by one clock.
- R9: A read at any index other than 0xFE or 0xFF returns 0x00. A write to such an index changes neither the status nor the mask.
- R10: Without a data write at 0xFE, a set status bit stays set. This includes writes to the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_we | input | 1 | Write strobe for the address port |
| data_we | input | 1 | Write strobe for the data port |
| wdata | input | 8 | Write byte shared by both ports |
| rdata | output | 8 | Data-port read value at the held index |
| bus_mode | input | 2 | Host bus width strap |
| ev_rx_done | input | 1 | Receive-done pulse |
| ev_tx_done | input | 1 | Transmit-done pulse |
| ev_rx_ovf | input | 1 | Receive-overflow pulse |
| ev_cnt_ovf | input | 1 | Overflow-counter overflow pulse |
| irq | output | 1 | Registered interrupt request |
| ptr_wrap | output | 1 | Pointer auto-wrap enable (mask bit 7) |

## Verification
The bench targets an event that collides with a write-1 clear of the same bit. A design that lets the clear win would lose that event, and the bench sees the status bit drop. It also writes zeros and ones into the upper status byte. A design without a per-bit clear would wipe unrelated bits, and one without read-only mode bits would corrupt the strap field. Writes to an unmapped index and writes to the mask are checked to leave the status untouched, which catches a loose index decode. The interrupt is sampled in the cycle right after a status change and again one cycle later. This exposes both an unregistered output and a second pipeline stage.

// File: rtl/nic_regport_pkg.sv
// Shared constants for the indexed interrupt register port.
// Assumes byte-wide registers and four event sources.
package nic_regport_pkg;
    localparam int DW        = 8;
    localparam int NEV       = 4;
    localparam int MODE_LSB  = 6;
    localparam int WRAP_BIT  = 7;
    localparam logic [DW-1:0] IDX_ISTAT = 8'hFE;
    localparam logic [DW-1:0] IDX_IMASK = 8'hFF;
endpackage

// File: rtl/nic_idx_latch.sv
// Holds the register index last written through the address port.
// Assumes the strobe is single-cycle and that the index resets to zero.
module nic_idx_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] din,
    output logic [W-1:0] idx
);
    // Capture a new index on each address-port write.
    always_ff @(posedge clk) begin
        if (!rst_n)  idx <= '0;
        else if (we) idx <= din;
    end
endmodule

// File: rtl/nic_irq_status.sv
// Event-set, write-1-clear status bits.
// Assumes events are single-cycle pulses. An event beats a clear in the same cycle.
module nic_irq_status #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_en,
    input  logic [N-1:0] clr_bits,
    input  logic [N-1:0] ev,
    output logic [N-1:0] sts
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic nxt;
        // Next value of one bit: kept unless cleared, always set by its event.
        always_comb nxt = (sts[i] & ~(clr_en & clr_bits[i])) | ev[i];
        // Register the bit.
        always_ff @(posedge clk) begin
            if (!rst_n) sts[i] <= 1'b0;
            else        sts[i] <= nxt;
        end
    end
endmodule

// File: rtl/nic_irq_mask.sv
// Mask register: N interrupt enables plus the pointer-wrap enable.
// Assumes unused middle bits are not stored and read back as zero.
module nic_irq_mask #(
    parameter int N  = 4,
    parameter int W  = 8,
    parameter int WB = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] din,
    output logic [N-1:0] en,
    output logic         wrap
);
    // Load the enables and the wrap bit on a data write at the mask index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en   <= '0;
            wrap <= 1'b0;
        end else if (we) begin
            en   <= din[N-1:0];
            wrap <= din[WB];
        end
    end
endmodule

// File: rtl/nic_regport.sv
// Indexed register port: address port selects, data port reads/writes.
// Assumes the host does not rely on an address and a data write in one cycle
// (the data write then uses the previous index).
module nic_regport
    import nic_regport_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          addr_we,
    input  logic          data_we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic [1:0]    bus_mode,
    input  logic          ev_rx_done,
    input  logic          ev_tx_done,
    input  logic          ev_rx_ovf,
    input  logic          ev_cnt_ovf,
    output logic          irq,
    output logic          ptr_wrap
);
    localparam int GAP_S = MODE_LSB - NEV;
    localparam int GAP_M = WRAP_BIT - NEV;

    logic [DW-1:0]  idx_q;
    logic [NEV-1:0] ev_vec;
    logic [NEV-1:0] sts_q;
    logic [NEV-1:0] msk_en;
    logic           msk_wrap;
    logic           hit_stat;
    logic           hit_mask;
    logic           irq_q;

    // Gather the event pulses into status bit order.
    always_comb ev_vec = {ev_cnt_ovf, ev_rx_ovf, ev_tx_done, ev_rx_done};

    // Decode the held index.
    always_comb begin
        hit_stat = (idx_q == IDX_ISTAT);
        hit_mask = (idx_q == IDX_IMASK);
    end

    nic_idx_latch #(.W(DW)) u_idx (
        .clk(clk), .rst_n(rst_n), .we(addr_we), .din(wdata), .idx(idx_q)
    );

    nic_irq_status #(.N(NEV)) u_sts (
        .clk(clk), .rst_n(rst_n), .clr_en(data_we & hit_stat),
        .clr_bits(wdata[NEV-1:0]), .ev(ev_vec), .sts(sts_q)
    );

    nic_irq_mask #(.N(NEV), .W(DW), .WB(WRAP_BIT)) u_msk (
        .clk(clk), .rst_n(rst_n), .we(data_we & hit_mask), .din(wdata),
        .en(msk_en), .wrap(msk_wrap)
    );

    // Read mux: status with mode strap, mask with wrap, zero elsewhere.
    always_comb begin
        if (hit_stat)      rdata = {bus_mode, {GAP_S{1'b0}}, sts_q};
        else if (hit_mask) rdata = {msk_wrap, {GAP_M{1'b0}}, msk_en};
        else               rdata = '0;
    end

    // Register the interrupt from the masked status.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(sts_q & msk_en);
    end

    assign irq      = irq_q;
    assign ptr_wrap = msk_wrap;
endmodule

// File: rtl/nic_regport_chk.sv
// Property checker for nic_regport, attached by bind below.
module nic_regport_chk
    import nic_regport_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic           data_we,
    input logic [DW-1:0]  wdata,
    input logic [DW-1:0]  idx_q,
    input logic [DW-1:0]  rdata,
    input logic [1:0]     bus_mode,
    input logic [NEV-1:0] ev_vec,
    input logic [NEV-1:0] sts_q,
    input logic [NEV-1:0] msk_en,
    input logic           irq
);
    logic past_ok;
    // Mark cycles whose predecessor was out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && |ev_vec) |=> ((sts_q & $past(ev_vec)) == $past(ev_vec))); // R3
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && data_we && idx_q == IDX_ISTAT)
        |=> ((sts_q & $past(wdata[NEV-1:0] & ~ev_vec)) == '0)); // R4
    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && data_we && idx_q == IDX_ISTAT && |(wdata[NEV-1:0] & ev_vec))
        |=> ((sts_q & $past(wdata[NEV-1:0] & ev_vec)) == $past(wdata[NEV-1:0] & ev_vec))); // R5
    AST_HOLD_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !(data_we && idx_q == IDX_ISTAT))
        |=> ((sts_q & $past(sts_q)) == $past(sts_q))); // R10
    AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |=> (irq == $past(|(sts_q & msk_en)))); // R8
    AST_MODE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_q == IDX_ISTAT) |-> (rdata[7:6] == bus_mode && rdata[5:4] == 2'b00)); // R6
    AST_MASK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_q == IDX_IMASK) |-> (rdata[6:4] == 3'b000)); // R7
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_q != IDX_ISTAT && idx_q != IDX_IMASK) |-> (rdata == '0)); // R9
endmodule

bind nic_regport nic_regport_chk u_chk (
    .clk(clk), .rst_n(rst_n), .data_we(data_we), .wdata(wdata),
    .idx_q(idx_q), .rdata(rdata), .bus_mode(bus_mode), .ev_vec(ev_vec),
    .sts_q(sts_q), .msk_en(msk_en), .irq(irq)
);

// File: tb/tb_nic_regport.sv
module tb_nic_regport;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr_we = 1'b0, data_we = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [1:0] bus_mode = 2'b10;
    logic [3:0] ev = '0;
    logic       irq, ptr_wrap;
    int         n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;

    nic_regport dut (
        .clk(clk), .rst_n(rst_n), .addr_we(addr_we), .data_we(data_we),
        .wdata(wdata), .rdata(rdata), .bus_mode(bus_mode),
        .ev_rx_done(ev[0]), .ev_tx_done(ev[1]), .ev_rx_ovf(ev[2]),
        .ev_cnt_ovf(ev[3]), .irq(irq), .ptr_wrap(ptr_wrap)
    );

    // op(2) val(8) ev(4) exp_rdata(8) exp_irq(1); op 0 idle, 1 address, 2 data
    localparam int NV = 16;
    localparam logic [22:0] VEC [NV] = '{
        {2'd1, 8'hFE, 4'h0, 8'h80, 1'b0},  // R1 R6 select status
        {2'd0, 8'h00, 4'h1, 8'h81, 1'b0},  // R3 rx done
        {2'd0, 8'h00, 4'h2, 8'h83, 1'b0},  // R3 tx done
        {2'd0, 8'h00, 4'hC, 8'h8F, 1'b0},  // R3 overflows
        {2'd2, 8'h05, 4'h0, 8'h8A, 1'b0},  // R4 clear bits 0,2
        {2'd2, 8'hF0, 4'h0, 8'h8A, 1'b0},  // R4 R6 zeros keep, mode fixed
        {2'd1, 8'hFF, 4'h0, 8'h00, 1'b0},  // R7 select mask
        {2'd2, 8'hFF, 4'h0, 8'h8F, 1'b1},  // R7 R8 mask all
        {2'd2, 8'h01, 4'h0, 8'h01, 1'b0},  // R8 only rx enabled
        {2'd0, 8'h00, 4'h1, 8'h01, 1'b1},  // R8 R10 event during mask index
        {2'd1, 8'h05, 4'h0, 8'h00, 1'b1},  // R9 unmapped read
        {2'd2, 8'hFF, 4'h0, 8'h00, 1'b1},  // R9 unmapped write
        {2'd1, 8'hFE, 4'h0, 8'h8B, 1'b1},  // R9 R10 status untouched
        {2'd2, 8'h01, 4'h1, 8'h8B, 1'b1},  // R5 event beats clear
        {2'd2, 8'h0B, 4'h0, 8'h80, 1'b0},  // R4 R8 clear all
        {2'd1, 8'h00, 4'h0, 8'h00, 1'b0}   // R9 index zero
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Drive one access for one edge, then idle one edge; ends at a negedge.
    task automatic step(input logic [1:0] op, input logic [7:0] val, input logic [3:0] e);
        @(negedge clk);
        addr_we = (op == 2'd1);
        data_we = (op == 2'd2);
        wdata = val;
        ev = e;
        @(negedge clk);
        addr_we = 1'b0; data_we = 1'b0; ev = '0;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 R2 rdata at reset", rdata, 8'h00);
        check("R2 irq at reset", {7'd0, irq}, 8'h00);
        check("R2 wrap at reset", {7'd0, ptr_wrap}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][22:21], VEC[i][20:13], VEC[i][12:9]);
            check($sformatf("vec%0d rdata", i), rdata, VEC[i][8:1]);
            check($sformatf("vec%0d irq", i), {7'd0, irq}, {7'd0, VEC[i][0]});
        end

        // R8: one-cycle latency of irq after an enabled event
        step(2'd1, 8'hFF, 4'h0);
        step(2'd2, 8'h02, 4'h0);
        @(negedge clk); ev = 4'h2;
        @(negedge clk); ev = 4'h0;
        check("R8 irq not yet", {7'd0, irq}, 8'h00);
        @(negedge clk);
        check("R8 irq after one cycle", {7'd0, irq}, 8'h01);

        // R7: wrap enable follows mask bit 7, middle bits read zero
        step(2'd2, 8'hF0, 4'h0);
        check("R7 mask readback", rdata, 8'h80);
        check("R7 ptr_wrap", {7'd0, ptr_wrap}, 8'h01);

        // R6: other strap values
        step(2'd1, 8'hFE, 4'h0);
        bus_mode = 2'b01; #1;
        check("R6 mode 32-bit", rdata, 8'h42);
        bus_mode = 2'b00; #1;
        check("R6 mode 16-bit", rdata, 8'h02);

        // R2: mid-run reset clears status, mask and irq
        step(2'd0, 8'h00, 4'hF);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R2 irq after reset", {7'd0, irq}, 8'h00);
        check("R2 wrap after reset", {7'd0, ptr_wrap}, 8'h00);
        step(2'd1, 8'hFE, 4'h0);
        check("R2 status after reset", rdata, 8'h00);
        step(2'd1, 8'hFF, 4'h0);
        check("R2 mask after reset", rdata, 8'h00);

        finish_run();
    end
endmodule